// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block rearranges the elements of one vector register under a per-element mask. In compress mode it gathers the elements whose mask bit is set and packs them, in their original order, into the lowest destination positions. In expand mode it does the reverse. It takes consecutive source elements from position 0 upward and scatters them into the destination positions whose mask bit is set. Both modes report how many mask bits were set, which is the length of the packed vector.

A request is a one-cycle `start` pulse. On that pulse the block captures the source vector, the prior destination contents, the mask, the mode and the vector length. It then walks the elements at one per clock. A running count of set mask bits chooses the write slot (compress) or the read slot (expand). One cycle after the last element, `done` pulses, and the result stays on `dst_vec_out` and `packed_len` until the next request is accepted. Element i occupies bits `[i*EW +: EW]` of every vector port, and mask bit i belongs to element i.

Top module: `vcx_unit`

## Requirements
- R1: While reset is held and after its release, `busy` and `done` are 0 and `packed_len` is 0.
- R2: With `mode` = 0 (compress), each element i below the effective length whose mask bit i is 1 is written to destination positions 0, 1, 2, ..., taken in ascending i. For example, mask bits 1, 4, 5 and 7 set with length 8 yields source elements 1, 4, 5, 7 in destination positions 0 to 3.
- R3: `packed_len` equals the number of mask bits set below the effective length, in both modes. It is valid from the `done` cycle until the next accepted start.
- R4: In compress mode, destination positions at or above `packed_len` keep the value captured from `dst_vec_in`.
- R5: With `mode` = 1 (expand), the k-th set mask bit in ascending position order (k counted from 0) receives source element k.
- R6: In expand mode, destination positions whose mask bit is 0, and all positions at or above the effective length, keep the value captured from `dst_vec_in`.
- R7: The effective length is `vlen`, limited to NELEM. Mask bits at or above it have no effect. A length of 0 writes nothing and reports 0.
- R8: If `start` is accepted in cycle c with effective length L, then `busy` is 1 in cycles c+1 to c+L, `done` is 1 for exactly cycle c+L+1, and `dst_vec_out` holds the result from that cycle on.
- R9: A `start` that arrives while `busy` is 1 is ignored. It does not change the running operation and produces no extra `done`.
- R10: A `start` that arrives in the `done` cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, accepted when not busy |
| mode | input | 1 | 0 selects compress, 1 selects expand |
| vlen | input | $clog2(NELEM+1) | Vector length of the request |
| mask | input | NELEM | One mask bit per element |
| src_vec | input | NELEM*EW | Source vector |
| dst_vec_in | input | NELEM*EW | Prior destination contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| packed_len | output | $clog2(NELEM+1) | Count of set mask bits below the length |
| dst_vec_out | output | NELEM*EW | Resulting destination vector |

## Verification
Two functions can land on the same clock: the completion pulse of one operation, and the acceptance of a new request that is presented in that cycle. The bench waits for `done`, raises `start` for a second operation in that same cycle, and then checks two things. The first result must match its model at its pulse. The second must complete exactly L+1 cycles later with its own correct vector and length. A second collision is also provoked: `start` with different data is pulsed in the middle of a running operation. That case is judged by the absence of any unscheduled `done` and by an unchanged result.

// File: rtl/vcx_pkg.sv
// Package: shared type of the compress/expand unit.
// Assumes: nothing beyond standard SystemVerilog.
package vcx_pkg;

    typedef enum logic {
        VCX_COMPRESS = 1'b0,
        VCX_EXPAND   = 1'b1
    } vcx_mode_e;

endpackage

// File: rtl/vcx_seq.sv
// Module: vcx_seq
// Walks the elements of a request one per cycle and keeps the running
// count of set mask bits seen so far. Produces busy/done and the write
// enable for the element store.
// Assumes: vl_eff is already limited to NELEM; start is sampled only when idle.
module vcx_seq
    import vcx_pkg::*;
#(
    parameter int NELEM = 64,
    localparam int IW = $clog2(NELEM),
    localparam int LW = $clog2(NELEM + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  vcx_mode_e       mode_in,
    input  logic [LW-1:0]   vl_eff,
    input  logic [NELEM-1:0] mask_in,
    output logic            busy,
    output logic            done,
    output logic            load,
    output logic [IW-1:0]   idx,
    output logic [LW-1:0]   cnt,
    output logic            wen,
    output vcx_mode_e       mode
);

    logic             busy_q;
    logic             done_q;
    logic [IW-1:0]    idx_q;
    logic [LW-1:0]    cnt_q;
    logic [LW-1:0]    vl_q;
    logic [NELEM-1:0] mask_q;
    vcx_mode_e        mode_q;
    logic             last_el;

    assign load    = start && !busy_q;
    assign last_el = (LW'(idx_q) == (vl_q - LW'(1)));

    // Request capture, element stepping and running set-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            idx_q  <= '0;
            cnt_q  <= '0;
            vl_q   <= '0;
            mask_q <= '0;
            mode_q <= VCX_COMPRESS;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                mask_q <= mask_in;
                mode_q <= mode_in;
                vl_q   <= vl_eff;
                idx_q  <= '0;
                cnt_q  <= '0;
                if (vl_eff == '0) begin
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                end
            end else if (busy_q) begin
                if (mask_q[idx_q]) begin
                    cnt_q <= cnt_q + LW'(1);
                end
                idx_q <= idx_q + IW'(1);
                if (last_el) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign idx  = idx_q;
    assign cnt  = cnt_q;
    assign wen  = busy_q && mask_q[idx_q];
    assign mode = mode_q;

endmodule

// File: rtl/vcx_store.sv
// Module: vcx_store
// Holds the captured source vector and the destination vector. Each write
// cycle moves one source element into one destination slot. Compress reads
// at the element index and writes at the running count; expand swaps them.
// Assumes: the running count never exceeds the element index while writing.
module vcx_store
    import vcx_pkg::*;
#(
    parameter int NELEM = 64,
    parameter int EW    = 16,
    localparam int IW = $clog2(NELEM),
    localparam int VW = NELEM * EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] src_in,
    input  logic [VW-1:0] dst_in,
    input  logic          wen,
    input  vcx_mode_e     mode,
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] cnt,
    output logic [VW-1:0] dst_out
);

    logic [EW-1:0] src_q [NELEM];
    logic [EW-1:0] dst_q [NELEM];
    logic [IW-1:0] rd_sel;
    logic [IW-1:0] wr_sel;
    logic [EW-1:0] rd_data;

    // Slot selection by mode.
    always_comb begin
        rd_sel  = (mode == VCX_EXPAND) ? cnt : idx;
        wr_sel  = (mode == VCX_EXPAND) ? idx : cnt;
        rd_data = src_q[rd_sel];
    end

    for (genvar g = 0; g < NELEM; g++) begin : g_elem
        // Source element capture on request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[g] <= '0;
            end else if (load) begin
                src_q[g] <= src_in[g*EW +: EW];
            end
        end

        // Destination element: preload on request, overwrite when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_q[g] <= '0;
            end else if (load) begin
                dst_q[g] <= dst_in[g*EW +: EW];
            end else if (wen && (wr_sel == IW'(g))) begin
                dst_q[g] <= rd_data;
            end
        end

        assign dst_out[g*EW +: EW] = dst_q[g];
    end

endmodule

// File: rtl/vcx_unit.sv
// Module: vcx_unit (top)
// Mask-driven compress/expand of one vector register, one element per cycle,
// with a start/done handshake.
// Assumes: vlen above NELEM means NELEM; start is ignored while busy.
module vcx_unit
    import vcx_pkg::*;
#(
    parameter int NELEM = 64,
    parameter int EW    = 16,
    localparam int IW = $clog2(NELEM),
    localparam int LW = $clog2(NELEM + 1),
    localparam int VW = NELEM * EW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [LW-1:0]    vlen,
    input  logic [NELEM-1:0] mask,
    input  logic [VW-1:0]    src_vec,
    input  logic [VW-1:0]    dst_vec_in,
    output logic             busy,
    output logic             done,
    output logic [LW-1:0]    packed_len,
    output logic [VW-1:0]    dst_vec_out
);

    logic [LW-1:0] vl_eff;
    logic          seq_load;
    logic [IW-1:0] seq_idx;
    logic [LW-1:0] seq_cnt;
    logic [IW-1:0] cnt_lo;
    logic          seq_wen;
    vcx_mode_e     seq_mode;

    // Length limit to the register size.
    always_comb begin
        vl_eff = (vlen > LW'(NELEM)) ? LW'(NELEM) : vlen;
    end

    assign cnt_lo     = seq_cnt[IW-1:0];
    assign packed_len = seq_cnt;

    vcx_seq #(.NELEM(NELEM)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (vcx_mode_e'(mode)),
        .vl_eff  (vl_eff),
        .mask_in (mask),
        .busy    (busy),
        .done    (done),
        .load    (seq_load),
        .idx     (seq_idx),
        .cnt     (seq_cnt),
        .wen     (seq_wen),
        .mode    (seq_mode)
    );

    vcx_store #(.NELEM(NELEM), .EW(EW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seq_load),
        .src_in  (src_vec),
        .dst_in  (dst_vec_in),
        .wen     (seq_wen),
        .mode    (seq_mode),
        .idx     (seq_idx),
        .cnt     (cnt_lo),
        .dst_out (dst_vec_out)
    );

endmodule

// File: rtl/vcx_unit_chk.sv
// Module: vcx_unit_chk
// Temporal checks on the handshake and the running count of vcx_unit.
// Assumes: bound into every vcx_unit instance by the bind below.
module vcx_unit_chk #(
    parameter int IW = 6,
    parameter int LW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [IW-1:0] idx,
    input logic [LW-1:0] cnt
);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(start)));

    a_r9_busy_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (idx == IW'($past(idx) + 1'b1)));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((cnt == $past(cnt)) || (cnt == LW'($past(cnt) + 1'b1))));

    a_r3_count_le_index: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LW'(idx)));

endmodule

bind vcx_unit vcx_unit_chk #(.IW(IW), .LW(LW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .idx   (seq_idx),
    .cnt   (seq_cnt)
);

// File: tb/test_vcx_unit.sv
// Scoreboard bench for vcx_unit: the driver pushes model results, the
// monitor pops and compares them at each done pulse.
module test_vcx_unit;

    localparam int NE = 64;
    localparam int EW = 16;
    localparam int LW = $clog2(NE + 1);
    localparam int VW = NE * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [LW-1:0] vlen = '0;
    logic [NE-1:0] mask = '0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] dst_in = '0;
    logic          busy;
    logic          done;
    logic [LW-1:0] packed_len;
    logic [VW-1:0] dst_out;

    typedef struct {
        logic [VW-1:0] dst;
        logic [LW-1:0] len;
        int unsigned   due;
        string         tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    vcx_unit #(.NELEM(NE), .EW(EW)) i_vcx_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .vlen        (vlen),
        .mask        (mask),
        .src_vec     (src_vec),
        .dst_vec_in  (dst_in),
        .busy        (busy),
        .done        (done),
        .packed_len  (packed_len),
        .dst_vec_out (dst_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < VW / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Reference model written from the requirements (R2..R7).
    task automatic model(input bit m, input int vl, input logic [NE-1:0] mk,
                         input logic [VW-1:0] s, input logic [VW-1:0] d,
                         output logic [VW-1:0] r, output int n);
        int v;
        v = (vl > NE) ? NE : vl;
        r = d;
        n = 0;
        for (int i = 0; i < v; i++) begin
            if (mk[i]) begin
                if (!m) r[n*EW +: EW] = s[i*EW +: EW];
                else    r[i*EW +: EW] = s[n*EW +: EW];
                n++;
            end
        end
    endtask

    // Driver: computes the expectation, queues it, pulses start for one cycle.
    task automatic apply(input bit m, input int vl, input logic [NE-1:0] mk,
                         input string tag);
        logic [VW-1:0] s, d, r;
        int            n, v;
        exp_t          e;
        s = rand_vec();
        d = rand_vec();
        model(m, vl, mk, s, d, r, n);
        v = (vl > NE) ? NE : vl;
        e.dst = r;
        e.len = LW'(n);
        e.due = cyc + 1 + v;
        e.tag = tag;
        sb.push_back(e);
        mode    = m;
        vlen    = LW'(vl);
        mask    = mk;
        src_vec = s;
        dst_in  = d;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (sb.size() != 0);
        @(negedge clk);
    endtask

    // Monitor: compares each completion against the queue head.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", VW'(1), VW'(0));
            end else begin
                e = sb.pop_front();
                chk(dst_out === e.dst, e.tag, "destination", dst_out, e.dst);
                chk(packed_len === e.len, {e.tag, " R3"}, "packed length",
                    VW'(packed_len), VW'(e.len));
                chk(cyc == e.due, "R8", "done cycle", VW'(cyc), VW'(e.due));
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R1", "busy in reset", VW'(busy), VW'(0));
        chk(done === 1'b0, "R1", "done in reset", VW'(done), VW'(0));
        chk(packed_len === '0, "R1", "length in reset", VW'(packed_len), VW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "idle after reset",
            VW'({busy, done}), VW'(0));

        // Mask bits 1,4,5,7 over eight elements.
        apply(1'b0, 8, 64'hB2, "R2 R4");
        drain();
        apply(1'b1, 8, 64'hB2, "R5 R6");
        drain();
        // Full length, all set and none set.
        apply(1'b0, 64, {NE{1'b1}}, "R2");
        drain();
        apply(1'b1, 64, {NE{1'b1}}, "R5");
        drain();
        apply(1'b0, 64, '0, "R4");
        drain();
        apply(1'b1, 64, '0, "R6");
        drain();
        // Zero length and mask bits above the length.
        apply(1'b0, 0, {NE{1'b1}}, "R7");
        drain();
        apply(1'b0, 10, 64'hFFFF_FFFF_FFFF_FC05, "R7 R2");
        drain();
        apply(1'b1, 10, 64'hFFFF_FFFF_FFFF_FC05, "R7 R6");
        drain();
        apply(1'b1, 100, 64'h8000_0000_0000_0001, "R7 R5");
        drain();
        // Mixed patterns.
        for (int t = 0; t < 8; t++) begin
            apply(t[0], 1 + ($urandom % 64), {$urandom, $urandom}, "R2 R5");
            drain();
        end

        // Start during a running operation must be ignored.
        apply(1'b0, 20, {$urandom, $urandom}, "R9 R2");
        repeat (3) @(negedge clk);
        chk(busy === 1'b1, "R9", "busy mid-run", VW'(busy), VW'(1));
        mode    = 1'b1;
        vlen    = LW'(5);
        mask    = '1;
        src_vec = rand_vec();
        dst_in  = rand_vec();
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        drain();
        repeat (30) @(negedge clk);

        // Start in the done cycle is accepted.
        apply(1'b1, 10, {$urandom, $urandom}, "R10 R5 R6");
        do @(negedge clk); while (!done);
        apply(1'b0, 12, {$urandom, $urandom}, "R10 R2 R4");
        do @(negedge clk); while (!done);
        apply(1'b0, 0, '1, "R10 R7");
        drain();
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R9", "pending items", VW'(sb.size()), VW'(0));

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule